// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block decides when a small RISC core enters one of two exceptions: a reset and a system break that cannot be masked. It takes the reset pin, the break pin, a boot-mode strap, the interrupt-enable bit and a strobe that marks each retiring instruction. From these it produces a redirect request with a target address. On reset it also writes the mode, interrupt-enable and carry bits of the status word.

Reset wins in every cycle in which its pin is low, whatever the pipeline is doing. The break pin passes through a synchronizer, and only its falling edge raises a pending request. That request waits for an instruction to complete. It never fires straight after a 16-bit non-branch instruction that starts on a word boundary. Instead it moves to the next retire that is allowed.

Top module: `exc_entry_ctrl`

## Requirements
- R1: In every clock edge that samples `rst_n` low, the following cycle shows `redir_valid` = 1, and `redir_addr` = `RESET_VEC` (default 0x0000_0000) when `boot_mode` = 0.
- R2: A reset with `boot_mode` = 1 redirects to `BOOT_VEC` (default 0x0000_8000).
- R3: A reset entry drives `psw_wr` = 1 with `psw_sm`, `psw_ie` and `psw_c` all 0. Outside reset, `psw_wr` stays 0.
- R4: Reset discards a pending break, so an eligible retire after reset release gives no redirect.
- R5: A break is requested only by a high-to-low transition of `sbrk_n`. Holding the pin low after a break has been taken causes no further entry.
- R6: A break is taken whatever the value of `ie_bit`.
- R7: A pending break is taken only on a cycle with `ret_valid` = 1. No redirect happens while no instruction retires.
- R8: A retire with `ret_len16` = 1, `ret_word_start` = 1 and `ret_branch` = 0 does not take a pending break. The break is then taken at the next eligible retire.
- R9: A pending break is taken after a 16-bit branch that starts on a word boundary, and after a 16-bit instruction that does not start on one (`ret_word_start` = 0).
- R10: A break entry is one cycle of `redir_valid` = 1 with `redir_addr` = `SBRK_VEC` (default 0x0000_0010) and `psw_wr` = 0. It appears in the cycle after the edge that samples the eligible retire.
- R11: When reset and an eligible retire with a pending break fall in the same cycle, the redirect goes to the reset address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; also the reset exception request |
| sbrk_n | input | 1 | Active-low system break pin, asynchronous |
| boot_mode | input | 1 | Boot strap; selects the boot address on reset |
| ie_bit | input | 1 | Current interrupt-enable bit (has no effect on breaks) |
| ret_valid | input | 1 | An instruction completes this cycle |
| ret_len16 | input | 1 | The retiring instruction is 16 bits long |
| ret_word_start | input | 1 | The retiring instruction starts on a word boundary |
| ret_branch | input | 1 | The retiring instruction is a branch |
| redir_valid | output | 1 | Fetch redirect request |
| redir_addr | output | ADDR_W | Redirect target |
| psw_wr | output | 1 | Write strobe for the status bits below |
| psw_sm | output | 1 | New stack-mode bit |
| psw_ie | output | 1 | New interrupt-enable bit |
| psw_c | output | 1 | New carry bit |

## Verification
The break path is tried with several retire shapes after a falling edge: a 32-bit instruction, a 16-bit instruction at a word start (alone, and then followed by a 32-bit one), a 16-bit branch at a word start, and a 16-bit instruction in the upper half. Together these separate the deferral rule from plain acceptance and from the branch exception to that rule. Idle cycles with no retire show that a break waits for completion. A pin held low after entry shows edge capture as opposed to level capture. Running with IE cleared shows that the mask has no effect. Resets with each boot strap value check the entry addresses and the status write. A reset during a pending break, together with a retire in the same cycle, checks priority and the clearing of the pending request.

// File: rtl/exc_entry_pkg.sv
// Package: shared retire descriptor and the break eligibility rule.
// Assumes one retire strobe per cycle at most.
package exc_entry_pkg;

    typedef struct packed {
        logic valid;
        logic len16;
        logic word_start;
        logic branch;
    } retire_t;

    // A completed instruction allows a break unless it is a 16-bit
    // non-branch that began on a word boundary.
    function automatic logic brk_allowed(input retire_t r);
        return r.valid && !(r.len16 && r.word_start && !r.branch);
    endfunction

endpackage

// File: rtl/sbrk_edge_det.sv
// Module: synchronizes the asynchronous active-low break pin through
// STAGES flops and flags one cycle per high-to-low transition.
// Assumes the pin idles high; all stages reset to the idle level.
module sbrk_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    // q[0..STAGES-1] is the synchronizer, q[STAGES] the history flop
    logic [STAGES:0] q;

    // Purpose: first stage samples the raw pin
    always_ff @(posedge clk) begin
        if (!rst_n) q[0] <= 1'b1;
        else        q[0] <= pin_n;
    end

    genvar g;
    generate
        for (g = 1; g <= STAGES; g++) begin : g_stage
            // Purpose: shift the pin level one stage further
            always_ff @(posedge clk) begin
                if (!rst_n) q[g] <= 1'b1;
                else        q[g] <= q[g-1];
            end
        end
    endgenerate

    assign fall = q[STAGES] & ~q[STAGES-1];

endmodule

// File: rtl/sbrk_pending.sv
// Module: holds a break request from its edge until it is taken at an
// eligible retire, or until reset drops it.
// Assumes a new edge in the take cycle re-arms the request.
module sbrk_pending
    import exc_entry_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fall,
    input  retire_t ret,
    output logic    take
);
    logic pend_q;

    assign take = pend_q && brk_allowed(ret);

    // Purpose: set on edge, clear on take, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= 1'b0;
        else if (fall) pend_q <= 1'b1;
        else if (take) pend_q <= 1'b0;
    end

endmodule

// File: rtl/entry_out.sv
// Module: registers the redirect request, its target and the status
// write. Reset has priority over a break take in the same cycle.
module entry_out #(
    parameter int              ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] BOOT_VEC  = '0,
    parameter logic [ADDR_W-1:0] SBRK_VEC  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode,
    input  logic              take,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              psw_wr
);
    // Purpose: choose reset entry, break entry, or idle each cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b1;
            redir_addr  <= boot_mode ? BOOT_VEC : RESET_VEC;
            psw_wr      <= 1'b1;
        end else begin
            redir_valid <= take;
            psw_wr      <= 1'b0;
            if (take) redir_addr <= SBRK_VEC;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Top: exception entry decision for reset and system break.
// Assumes rst_n is synchronous to clk; sbrk_n may be asynchronous.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] BOOT_VEC    = 32'h0000_8000,
    parameter logic [ADDR_W-1:0] SBRK_VEC    = 32'h0000_0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sbrk_n,
    input  logic              boot_mode,
    input  logic              ie_bit,
    input  logic              ret_valid,
    input  logic              ret_len16,
    input  logic              ret_word_start,
    input  logic              ret_branch,
    output logic              redir_valid,
    output logic [ADDR_W-1:0] redir_addr,
    output logic              psw_wr,
    output logic              psw_sm,
    output logic              psw_ie,
    output logic              psw_c
);
    retire_t ret;
    logic    fall;
    logic    take;
    logic    unused_ie;

    assign ret       = '{valid: ret_valid, len16: ret_len16,
                         word_start: ret_word_start, branch: ret_branch};
    assign unused_ie = ie_bit;  // breaks are not maskable

    // Entry writes all three status bits as zero
    assign psw_sm = 1'b0;
    assign psw_ie = 1'b0;
    assign psw_c  = 1'b0;

    sbrk_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (sbrk_n),
        .fall  (fall)
    );

    sbrk_pending i_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .fall  (fall),
        .ret   (ret),
        .take  (take)
    );

    entry_out #(
        .ADDR_W    (ADDR_W),
        .RESET_VEC (RESET_VEC),
        .BOOT_VEC  (BOOT_VEC),
        .SBRK_VEC  (SBRK_VEC)
    ) i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode   (boot_mode),
        .take        (take),
        .redir_valid (redir_valid),
        .redir_addr  (redir_addr),
        .psw_wr      (psw_wr)
    );

endmodule

// File: rtl/exc_entry_chk.sv
// Checker: temporal properties of the entry controller at its ports.
module exc_entry_chk #(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    parameter logic [ADDR_W-1:0] BOOT_VEC  = '0,
    parameter logic [ADDR_W-1:0] SBRK_VEC  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              boot_mode,
    input logic              ret_valid,
    input logic              ret_len16,
    input logic              ret_word_start,
    input logic              ret_branch,
    input logic              redir_valid,
    input logic [ADDR_W-1:0] redir_addr,
    input logic              psw_wr,
    input logic              psw_sm,
    input logic              psw_ie,
    input logic              psw_c
);
    logic brk_out;
    assign brk_out = redir_valid && !psw_wr;

    assert_reset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> redir_valid && psw_wr &&
            (redir_addr == ($past(boot_mode) ? BOOT_VEC : RESET_VEC)));

    assert_status_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        psw_wr |-> redir_valid && !psw_sm && !psw_ie && !psw_c);

    assert_only_on_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_out && !$rose(rst_n)) |-> $past(ret_valid));

    assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_out && !$rose(rst_n)) |->
            !$past(ret_len16 && ret_word_start && !ret_branch));

    assert_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out |-> redir_addr == SBRK_VEC);

    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_out |=> !brk_out);

endmodule

bind exc_entry_ctrl exc_entry_chk #(
    .ADDR_W    (ADDR_W),
    .RESET_VEC (RESET_VEC),
    .BOOT_VEC  (BOOT_VEC),
    .SBRK_VEC  (SBRK_VEC)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_mode      (boot_mode),
    .ret_valid      (ret_valid),
    .ret_len16      (ret_len16),
    .ret_word_start (ret_word_start),
    .ret_branch     (ret_branch),
    .redir_valid    (redir_valid),
    .redir_addr     (redir_addr),
    .psw_wr         (psw_wr),
    .psw_sm         (psw_sm),
    .psw_ie         (psw_ie),
    .psw_c          (psw_c)
);

// File: tb/test_exc_entry_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module test_exc_entry_ctrl;
    localparam int          AW   = 32;
    localparam logic [31:0] RVEC = 32'h0000_0000;
    localparam logic [31:0] BVEC = 32'h0000_8000;
    localparam logic [31:0] SVEC = 32'h0000_0010;

    logic clk = 1'b0;
    logic rst_n, sbrk_n, boot_mode, ie_bit;
    logic ret_valid, ret_len16, ret_word_start, ret_branch;
    logic redir_valid, psw_wr, psw_sm, psw_ie, psw_c;
    logic [AW-1:0] redir_addr;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .sbrk_n(sbrk_n), .boot_mode(boot_mode),
        .ie_bit(ie_bit), .ret_valid(ret_valid), .ret_len16(ret_len16),
        .ret_word_start(ret_word_start), .ret_branch(ret_branch),
        .redir_valid(redir_valid), .redir_addr(redir_addr), .psw_wr(psw_wr),
        .psw_sm(psw_sm), .psw_ie(psw_ie), .psw_c(psw_c)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // One retire for one cycle; sample the registered result afterwards
    task automatic retire(input logic l16, input logic ws, input logic br);
        ret_valid = 1'b1; ret_len16 = l16; ret_word_start = ws; ret_branch = br;
        step();
        ret_valid = 1'b0; ret_len16 = 1'b0; ret_word_start = 1'b0; ret_branch = 1'b0;
    endtask

    task automatic pull_break();
        sbrk_n = 1'b0;
        repeat (4) begin
            step();
            check("R7 idle", {63'd0, redir_valid}, 64'd0);
        end
    endtask

    task automatic release_pin();
        sbrk_n = 1'b1;
        repeat (4) step();
    endtask

    task automatic expect_break(input string req);
        check(req, {63'd0, redir_valid}, 64'd1);
        check(req, {32'd0, redir_addr}, {32'd0, SVEC});
        check(req, {63'd0, psw_wr}, 64'd0);
        step();
        check("R10 pulse", {63'd0, redir_valid}, 64'd0);
    endtask

    task automatic t_reset(input logic boot);
        boot_mode = boot;
        rst_n = 1'b0;
        repeat (2) begin
            step();
            check(boot ? "R2" : "R1", {63'd0, redir_valid}, 64'd1);
            check(boot ? "R2" : "R1", {32'd0, redir_addr}, {32'd0, boot ? BVEC : RVEC});
            check("R3", {60'd0, psw_wr, psw_sm, psw_ie, psw_c}, 64'h8);
        end
        rst_n = 1'b1;
        step();
        check("R3 after", {62'd0, psw_wr, redir_valid}, 64'd0);
        boot_mode = 1'b0;
    endtask

    task automatic t_basic_and_level();
        pull_break();
        retire(1'b0, 1'b1, 1'b0);
        expect_break("R10 basic");
        repeat (3) step();
        retire(1'b0, 1'b1, 1'b0);
        check("R5 level", {63'd0, redir_valid}, 64'd0);
        release_pin();
    endtask

    task automatic t_ie_low();
        ie_bit = 1'b0;
        pull_break();
        retire(1'b0, 1'b0, 1'b0);
        expect_break("R6");
        ie_bit = 1'b1;
        release_pin();
    endtask

    task automatic t_defer();
        pull_break();
        retire(1'b1, 1'b1, 1'b0);
        check("R8 defer", {63'd0, redir_valid}, 64'd0);
        step();
        check("R8 idle", {63'd0, redir_valid}, 64'd0);
        retire(1'b0, 1'b1, 1'b0);
        expect_break("R8 next");
        release_pin();
    endtask

    task automatic t_branch_and_upper();
        pull_break();
        retire(1'b1, 1'b1, 1'b1);
        expect_break("R9 branch");
        release_pin();
        pull_break();
        retire(1'b1, 1'b0, 1'b0);
        expect_break("R9 upper");
        release_pin();
    endtask

    task automatic t_reset_pending();
        pull_break();
        rst_n = 1'b0;
        ret_valid = 1'b1; ret_len16 = 1'b0; ret_word_start = 1'b1; ret_branch = 1'b0;
        step();
        ret_valid = 1'b0;
        check("R11", {32'd0, redir_addr}, {32'd0, RVEC});
        check("R11", {63'd0, psw_wr}, 64'd1);
        sbrk_n = 1'b1;
        step();
        rst_n = 1'b1;
        repeat (4) step();
        retire(1'b0, 1'b1, 1'b0);
        check("R4", {63'd0, redir_valid}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; sbrk_n = 1'b1; boot_mode = 1'b0; ie_bit = 1'b1;
        ret_valid = 1'b0; ret_len16 = 1'b0; ret_word_start = 1'b0; ret_branch = 1'b0;
        step();
        t_reset(1'b0);
        t_reset(1'b1);
        t_basic_and_level();
        t_ie_low();
        t_defer();
        t_branch_and_upper();
        t_reset_pending();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule